// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out store that sits between two unrelated clock domains. Words enter on the write clock and leave on the read clock. A read is requested with a strobe, and the word appears on the output after the read clock edge that accepts it. Write and read positions are kept as binary counters one bit wider than the address. Each domain publishes its position to the other as gray code through a two-flop synchroniser. Every flag is active-low.

The write side drives a full flag and a synchronous almost-full flag. The read side drives an empty flag and a synchronous almost-empty flag. The full flag stops writes and the empty flag stops reads. The almost-full and almost-empty thresholds come from offset registers, and each register can be reloaded from its own clock domain.

A mode input per almost flag chooses a second form of that flag. In this form the flag is set on an edge of one clock and released on an edge of the other. A half-full flag always works that way: it is set by a write and released by a read. A single active-low reset is asserted asynchronously and released synchronously inside each domain.

Top module: `dcfifo_pflag`

## Requirements
- R1: After reset, full_n=1, empty_n=0, paf_n=1, pae_n=0 and hf_n=1, and both pointers are zero.
- R2: Words leave in the order they were written. rd_data takes the next word on the rclk rising edge at which rd_en=1 and empty_n=1.
- R3: With no reads since reset, full_n goes low on the wclk edge of the DEPTH-th accepted write. A write attempted while full_n=0 is dropped, and it neither moves the write pointer nor lands in storage.
- R4: A read attempted while empty_n=0 is ignored: the read pointer and rd_data stay unchanged.
- R5: After a write into an empty FIFO, empty_n goes high no later than the third rclk rising edge after the write edge.
- R6: With paf_mode=0, paf_n is a wclk register that is low whenever the write-side occupancy is at least DEPTH minus the full offset m.
- R7: With pae_mode=0, pae_n is an rclk register that is low whenever the read-side occupancy is at most the empty offset n.
- R8: With paf_mode=1, paf_n goes low right after the wclk edge that brings the occupancy to DEPTH−m. It returns high right after the rclk edge that brings the occupancy below DEPTH−m.
- R9: With pae_mode=1, pae_n goes low right after the rclk edge that brings the occupancy to n or less. It returns high right after the wclk edge that makes the occupancy exceed n.
- R10: hf_n goes low right after the wclk edge that makes the occupancy exceed DEPTH/2 (write DEPTH/2+1 with no reads). It returns high right after the rclk edge that brings the occupancy to DEPTH/2 or less.
- R11: The offsets reset to DEF_FULL_OFS (m) and DEF_EMPTY_OFS (n). ofs_full_ld loads m from ofs_full_val on a wclk edge. ofs_empty_ld loads n from ofs_empty_val on an rclk edge. The new values move the thresholds of R6 to R9.
- R12: Each pointer crosses domains as gray code and changes at most one bit per edge. Neither domain's view of the occupancy ever exceeds DEPTH, so a full FIFO drains exactly DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to store |
| ofs_full_ld | input | 1 | Load strobe for the full offset (wclk) |
| ofs_full_val | input | AW | New full offset m |
| paf_mode | input | 1 | 0: almost-full synchronous, 1: set by write, cleared by read |
| full_n | output | 1 | Low when full |
| paf_n | output | 1 | Low when almost full |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Word read out |
| ofs_empty_ld | input | 1 | Load strobe for the empty offset (rclk) |
| ofs_empty_val | input | AW | New empty offset n |
| pae_mode | input | 1 | 0: almost-empty synchronous, 1: set by read, cleared by write |
| empty_n | output | 1 | Low when empty |
| pae_n | output | 1 | Low when almost empty |
| hf_n | output | 1 | Low when more than half full |

## Verification
The hardest case to reach is a flag that is set by one clock and released by the other. To show it, the stimulus must prove that the release comes on the opposite clock's edge itself and not several cycles later through a synchroniser. The bench first lets both domains settle. It then holds one domain idle and steps the other one word at a time, sampling on the falling edge straight after each step. This puts the occupancy exactly on the threshold and moves it across with a single write or a single read.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Selects how an almost flag is produced
  typedef enum logic {
    FLAG_SYNC  = 1'b0,  // registered in the flag's own clock domain
    FLAG_ASYNC = 1'b1   // set by one clock, released by the other
  } flag_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= '0;
      q    <= '0;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= ram[raddr];
  end
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside #(
  parameter int DEPTH   = 1024,
  parameter int DEF_OFS = 127,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          ofs_ld,
  input  logic [AW-1:0] ofs_val,
  input  logic [AW:0]   rgray_s,
  output logic          wr_ok,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] fofs,
  output logic          full_n,
  output logic          paf_s_n
);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [AW:0] rbin_s, wbin_nx, wcnt_nx, thr;
  logic        full_nx, paf_nx;

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
    wr_ok   = wr_en & full_n;
    wbin_nx = wbin + {{AW{1'b0}}, wr_ok};
    wcnt_nx = wbin_nx - rbin_s;
    thr     = FULLV - {1'b0, fofs};
    full_nx = (wcnt_nx != FULLV);
    paf_nx  = (wcnt_nx < thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      fofs    <= AW'(DEF_OFS);
      full_n  <= 1'b1;
      paf_s_n <= 1'b1;
    end else begin
      if (wr_ok) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (ofs_ld) fofs <= ofs_val;
      full_n  <= full_nx;
      paf_s_n <= paf_nx;
    end
  end

  assign waddr = wbin[AW-1:0];

  // R12
  wcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin - rbin_s) <= FULLV);
  // R12
  wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wbin));
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
  parameter int DEPTH   = 1024,
  parameter int DEF_OFS = 127,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          ofs_ld,
  input  logic [AW-1:0] ofs_val,
  input  logic [AW:0]   wgray_s,
  output logic          rd_ok,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] eofs,
  output logic          empty_n,
  output logic          pae_s_n
);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [AW:0] wbin_s, rbin_nx, rcnt_nx;
  logic        empty_nx, pae_nx;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    rd_ok    = rd_en & empty_n;
    rbin_nx  = rbin + {{AW{1'b0}}, rd_ok};
    rcnt_nx  = wbin_s - rbin_nx;
    empty_nx = (rcnt_nx != '0);
    pae_nx   = (rcnt_nx > {1'b0, eofs});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      eofs    <= AW'(DEF_OFS);
      empty_n <= 1'b0;
      pae_s_n <= 1'b0;
    end else begin
      if (rd_ok) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (ofs_ld) eofs <= ofs_val;
      empty_n <= empty_nx;
      pae_s_n <= pae_nx;
    end
  end

  assign raddr = rbin[AW-1:0];

  // R12
  rcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_s - rbin) <= FULLV);
  // R12
  rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
  // R4
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en) |=> $stable(rbin));
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DEPTH         = 1024,
  parameter int W             = 36,
  parameter int DEF_FULL_OFS  = 127,
  parameter int DEF_EMPTY_OFS = 127,
  localparam int AW           = $clog2(DEPTH)
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          ofs_full_ld,
  input  logic [AW-1:0] ofs_full_val,
  input  logic          paf_mode,
  output logic          full_n,
  output logic          paf_n,
  input  logic          rclk,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          ofs_empty_ld,
  input  logic [AW-1:0] ofs_empty_val,
  input  logic          pae_mode,
  output logic          empty_n,
  output logic          pae_n,
  output logic          hf_n
);
  import dcf_pkg::*;

  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALFV = (AW+1)'(DEPTH / 2);

  logic          wrst_n, rrst_n;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] waddr, raddr, fofs, eofs;
  logic [AW:0]   wbin, rbin, wgray, rgray, wgray_s, rgray_s;
  logic [AW:0]   occ, af_thr;
  logic          paf_s_n, pae_s_n, paf_a_n, pae_a_n;
  flag_mode_e    paf_sel, pae_sel;

  // Reset release aligned to each clock
  dcf_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  dcf_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  // Gray pointer crossings
  dcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_wside #(.DEPTH(DEPTH), .DEF_OFS(DEF_FULL_OFS)) u_wside (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en),
    .ofs_ld(ofs_full_ld), .ofs_val(ofs_full_val), .rgray_s(rgray_s),
    .wr_ok(wr_ok), .waddr(waddr), .wbin(wbin), .wgray(wgray), .fofs(fofs),
    .full_n(full_n), .paf_s_n(paf_s_n)
  );

  dcf_rside #(.DEPTH(DEPTH), .DEF_OFS(DEF_EMPTY_OFS)) u_rside (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en),
    .ofs_ld(ofs_empty_ld), .ofs_val(ofs_empty_val), .wgray_s(wgray_s),
    .rd_ok(rd_ok), .raddr(raddr), .rbin(rbin), .rgray(rgray), .eofs(eofs),
    .empty_n(empty_n), .pae_s_n(pae_s_n)
  );

  dcf_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(rd_ok), .raddr(raddr), .rdata(rd_data)
  );

  // Cross-domain flags: levels from both pointer registers, so a write
  // edge can set them and a read edge can release them (or vice versa)
  always_comb begin
    occ     = wbin - rbin;
    af_thr  = FULLV - {1'b0, fofs};
    paf_a_n = (occ < af_thr);
    pae_a_n = (occ > {1'b0, eofs});
    hf_n    = (occ <= HALFV);
    paf_sel = flag_mode_e'(paf_mode);
    pae_sel = flag_mode_e'(pae_mode);
    paf_n   = (paf_sel == FLAG_ASYNC) ? paf_a_n : paf_s_n;
    pae_n   = (pae_sel == FLAG_ASYNC) ? pae_a_n : pae_s_n;
  end
endmodule

// File: tb/test_dcfifo_pflag.sv
`timescale 1ns/1ps
module test_dcfifo_pflag;
  localparam int DEPTH = 16;
  localparam int W     = 36;
  localparam int M0    = 4;
  localparam int N0    = 3;
  localparam int AW    = $clog2(DEPTH);

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic          ofs_full_ld = 1'b0, ofs_empty_ld = 1'b0;
  logic [AW-1:0] ofs_full_val = '0, ofs_empty_val = '0;
  logic          paf_mode = 1'b0, pae_mode = 1'b0;
  logic          full_n, paf_n, empty_n, pae_n, hf_n;
  logic [W-1:0]  rd_data;

  int total = 0, bad = 0;
  logic [W-1:0] model[$];
  logic [W-1:0] seq = 36'h0_A000_0100;
  bit           done = 1'b0;

  always #2   wclk = ~wclk;   // 250 MHz write clock
  always #3.5 rclk = ~rclk;

  dcfifo_pflag #(.DEPTH(DEPTH), .W(W), .DEF_FULL_OFS(M0), .DEF_EMPTY_OFS(N0)) i_dcfifo_pflag (
    .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
    .ofs_full_ld(ofs_full_ld), .ofs_full_val(ofs_full_val), .paf_mode(paf_mode),
    .full_n(full_n), .paf_n(paf_n), .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data),
    .ofs_empty_ld(ofs_empty_ld), .ofs_empty_val(ofs_empty_val), .pae_mode(pae_mode),
    .empty_n(empty_n), .pae_n(pae_n), .hf_n(hf_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr1();
    @(negedge wclk); wr_en = 1'b1; wr_data = seq;
    @(negedge wclk); wr_en = 1'b0;
    if (model.size() < DEPTH) model.push_back(seq);
    seq++;
  endtask

  task automatic rd1();
    logic [W-1:0] exp;
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    if (model.size() > 0) begin
      exp = model.pop_front();
      chk("R2 read order", rd_data, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic drain();
    settle();
    while (model.size() > 0) rd1();
    settle();
    chk("R4 drained to empty", empty_n, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 full_n", full_n, 1'b1);
    chk("R1 empty_n", empty_n, 1'b0);
    chk("R1 paf_n", paf_n, 1'b1);
    chk("R1 pae_n", pae_n, 1'b0);
    chk("R1 hf_n", hf_n, 1'b1);
  endtask

  task automatic t_order();
    logic [W-1:0] prev;
    wr1();
    repeat (4) @(negedge rclk);
    chk("R5 empty_n released", empty_n, 1'b1);
    wr1(); wr1();
    settle();
    rd1(); rd1(); rd1();
    settle();
    chk("R4 empty after reads", empty_n, 1'b0);
    prev = rd_data;
    rd1();
    chk("R4 read on empty keeps data", rd_data, prev);
    chk("R4 read on empty stays empty", empty_n, 1'b0);
  endtask

  task automatic t_full();
    logic [W-1:0] prev;
    paf_mode = 1'b0;
    for (int k = 1; k <= DEPTH; k++) begin
      wr1();
      chk("R3 full_n per write", full_n, (k < DEPTH));
      chk("R6 sync paf_n per write", paf_n, (k < DEPTH - M0));
      chk("R10 hf_n per write", hf_n, (k <= DEPTH / 2));
    end
    wr1();  // dropped
    chk("R3 full_n after overflow try", full_n, 1'b0);
    settle();
    for (int j = 1; j <= DEPTH; j++) begin
      rd1();
      chk("R10 hf_n per read", hf_n, ((DEPTH - j) <= DEPTH / 2));
    end
    settle();
    chk("R12 exactly DEPTH words drained", empty_n, 1'b0);
    chk("R3 full_n released", full_n, 1'b1);
    prev = rd_data;
    rd1();
    chk("R3 dropped word never stored", rd_data, prev);
  endtask

  task automatic t_apaf();
    paf_mode = 1'b1;
    for (int k = 1; k <= DEPTH - M0; k++) begin
      wr1();
      chk("R8 async paf_n set by write", paf_n, (k < DEPTH - M0));
    end
    rd1();
    chk("R8 async paf_n released by read", paf_n, 1'b1);
    paf_mode = 1'b0;
    drain();
  endtask

  task automatic t_apae();
    pae_mode = 1'b1;
    chk("R9 async pae_n at empty", pae_n, 1'b0);
    for (int k = 1; k <= N0 + 1; k++) begin
      wr1();
      chk("R9 async pae_n released by write", pae_n, (k > N0));
    end
    rd1();
    chk("R9 async pae_n set by read", pae_n, 1'b0);
    drain();
    pae_mode = 1'b0;
  endtask

  task automatic t_spae();
    pae_mode = 1'b0;
    for (int k = 1; k <= N0 + 1; k++) wr1();
    settle();
    chk("R7 sync pae_n above n", pae_n, 1'b1);
    rd1();
    chk("R7 sync pae_n at n", pae_n, 1'b0);
    drain();
  endtask

  task automatic t_ofs();
    @(negedge wclk); ofs_full_ld = 1'b1; ofs_full_val = AW'(2);
    @(negedge wclk); ofs_full_ld = 1'b0;
    @(negedge rclk); ofs_empty_ld = 1'b1; ofs_empty_val = AW'(6);
    @(negedge rclk); ofs_empty_ld = 1'b0;
    for (int k = 1; k <= DEPTH - 2; k++) begin
      wr1();
      chk("R11 loaded m moves paf_n", paf_n, (k < DEPTH - 2));
    end
    settle();
    while (model.size() > 7) rd1();
    chk("R11 loaded n, count 7", pae_n, 1'b1);
    rd1();
    chk("R11 loaded n, count 6", pae_n, 1'b0);
    drain();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge wclk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_order();
    t_full();
    t_apaf();
    t_apae();
    t_spae();
    t_ofs();
    finish_up();
  end
endmodule